// File: doc/BRIEF.md
# Registered Bus Transceiver

This block exchanges a parameter-width word between two ports, side A and side B. Each direction has its own capture register. The A-to-B register samples the A input on the rising edge of its own capture clock. The B-to-A register samples the B input on the rising edge of a second, independent capture clock. Capture works at all times, whatever the state of the drive controls.

An active-low output enable and a direction input decide which port, if any, drives. When a port drives, a per-port select input chooses what it presents: live data taken from the opposite port's input, or the word held in the register that feeds it. Each port is a separate input vector, output vector and drive flag, so an enclosing level can resolve them onto tri-state pads.

The output paths contain no register. A change on a select, control or data input reaches the outputs in the same cycle.

Top module: `bus_xcvr_reg`

## Requirements
- R1: An active-low asynchronous reset clears both capture registers to zero. After reset, a driving port set to stored data presents 0x00.
- R2: A rising edge on `a_cap_clk` loads `a_in` into the A-to-B register.
- R3: A rising edge on `b_cap_clk` loads `b_in` into the B-to-A register.
- R4: Capture does not depend on `out_en_n` or `to_b`. Both registers load during isolation, and a register also loads while a port is driving.
- R5: While `out_en_n` is 1, both `a_drv` and `b_drv` are 0, and both `a_out` and `b_out` are all zeros.
- R6: While `out_en_n` is 0 and `to_b` is 0, `a_drv` is 1 and `b_drv` is 0. `b_out` is all zeros.
- R7: While `out_en_n` is 0 and `to_b` is 1, `b_drv` is 1 and `a_drv` is 0. `a_out` is all zeros.
- R8: While A drives, `a_out` equals `b_in` in the same cycle when `sel_a_stored` is 0. It equals the B-to-A register when `sel_a_stored` is 1. `sel_b_stored` has no effect on `a_out`.
- R9: While B drives, `b_out` equals `a_in` in the same cycle when `sel_b_stored` is 0. It equals the A-to-B register when `sel_b_stored` is 1. `sel_a_stored` has no effect on `b_out`.
- R10: `a_drv` and `b_drv` are never 1 at the same time.
- R11: Between capture edges, a register keeps its value however its bus input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| a_cap_clk | input | 1 | Capture clock of the A-to-B register |
| b_cap_clk | input | 1 | Capture clock of the B-to-A register |
| out_en_n | input | 1 | Active-low output enable |
| to_b | input | 1 | Direction: 0 = A port drives, 1 = B port drives |
| sel_a_stored | input | 1 | A port source: 0 = live B input, 1 = B-to-A register |
| sel_b_stored | input | 1 | B port source: 0 = live A input, 1 = A-to-B register |
| a_in | input | WIDTH | Value seen on the A bus |
| a_out | output | WIDTH | Value the A port drives |
| a_drv | output | 1 | A port output enable |
| b_in | input | WIDTH | Value seen on the B bus |
| b_out | output | WIDTH | Value the B port drives |
| b_drv | output | 1 | B port output enable |

## Verification
The assertions run on every cycle and check four things:
- the two drive flags never overlap;
- in isolation both ports are quiet;
- a live-routed port follows the opposite input;
- each register holds, one capture edge later, the value present at that edge.

Only the bench's scenarios can show the rest:
- the reset contents;
- the stored-data routing against words captured earlier;
- that a register keeps its value between edges;
- that capture continues while a port drives.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic [1:0] {
      DRV_NONE = 2'b00,
      DRV_A    = 2'b01,
      DRV_B    = 2'b10
   } drive_e;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
   parameter int WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             cap_clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] RESET_VAL = '0;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_cap_reg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge cap_clk or negedge rst_n) begin
      if (!rst_n) q <= RESET_VAL;
      else        q <= d;
   end

   // R2 / R3: a register holds, one edge later, the word present at the edge
   a_r2_r3_capture: assert property (@(posedge cap_clk) disable iff (!rst_n)
      1'b1 |=> (q == $past(d)))
      else $error("capture register lost the sampled word");
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
   import xcvr_pkg::*;
(
   input  logic   out_en_n,
   input  logic   to_b,
   output drive_e drive,
   output logic   a_drv,
   output logic   b_drv
);
   always_comb begin
      if (out_en_n)  drive = DRV_NONE;
      else if (to_b) drive = DRV_B;
      else           drive = DRV_A;
   end

   assign a_drv = (drive == DRV_A);
   assign b_drv = (drive == DRV_B);
endmodule

// File: rtl/xcvr_lane_sel.sv
module xcvr_lane_sel #(
   parameter int WIDTH = 8
) (
   input  logic             enable,
   input  logic             use_stored,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_lane_sel: WIDTH must be at least 1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_lane
         logic pick;
         assign pick   = use_stored ? stored[i] : live[i];
         assign out[i] = enable & pick;
      end
   endgenerate
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             rst_n,
   input  logic             a_cap_clk,
   input  logic             b_cap_clk,
   input  logic             out_en_n,
   input  logic             to_b,
   input  logic             sel_a_stored,
   input  logic             sel_b_stored,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drv,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drv
);
   localparam logic [WIDTH-1:0] ZERO = '0;

   drive_e           drive;
   logic [WIDTH-1:0] reg_ab;
   logic [WIDTH-1:0] reg_ba;

   xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_ab (
      .rst_n(rst_n), .cap_clk(a_cap_clk), .d(a_in), .q(reg_ab));

   xcvr_cap_reg #(.WIDTH(WIDTH)) u_reg_ba (
      .rst_n(rst_n), .cap_clk(b_cap_clk), .d(b_in), .q(reg_ba));

   xcvr_drive_ctrl u_ctrl (
      .out_en_n(out_en_n), .to_b(to_b), .drive(drive),
      .a_drv(a_drv), .b_drv(b_drv));

   xcvr_lane_sel #(.WIDTH(WIDTH)) u_sel_a (
      .enable(a_drv), .use_stored(sel_a_stored),
      .live(b_in), .stored(reg_ba), .out(a_out));

   xcvr_lane_sel #(.WIDTH(WIDTH)) u_sel_b (
      .enable(b_drv), .use_stored(sel_b_stored),
      .live(a_in), .stored(reg_ab), .out(b_out));

   always_comb begin
      if (rst_n) begin
         a_r10_one_driver: assert (!(a_drv && b_drv))
            else $error("both ports drive");
         a_r5_quiet: assert (!out_en_n || (!a_drv && !b_drv && a_out == ZERO && b_out == ZERO))
            else $error("port active in isolation");
         a_r8_a_live: assert (!(a_drv && !sel_a_stored) || a_out == b_in)
            else $error("A port not following live B input");
         a_r9_b_live: assert (!(b_drv && !sel_b_stored) || b_out == a_in)
            else $error("B port not following live A input");
      end
   end
endmodule

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;
   localparam int W = 8;

   typedef struct packed {
      logic         oen;
      logic         tob;
      logic         sa;
      logic         sb;
      logic [W-1:0] ain;
      logic [W-1:0] bin;
      logic [W-1:0] ea;
      logic         ead;
      logic [W-1:0] eb;
      logic         ebd;
      logic [3:0]   req;
   } vec_t;

   // registers hold AB=3C, BA=A5 while this table runs
   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,1'b0,8'h11,8'h22, 8'h00,1'b0,8'h00,1'b0, 4'd5},
      '{1'b1,1'b1,1'b1,1'b1,8'h11,8'h22, 8'h00,1'b0,8'h00,1'b0, 4'd5},
      '{1'b0,1'b0,1'b0,1'b0,8'h11,8'h22, 8'h22,1'b1,8'h00,1'b0, 4'd6},
      '{1'b0,1'b0,1'b1,1'b0,8'h11,8'h22, 8'hA5,1'b1,8'h00,1'b0, 4'd8},
      '{1'b0,1'b1,1'b0,1'b0,8'h11,8'h22, 8'h00,1'b0,8'h11,1'b1, 4'd7},
      '{1'b0,1'b1,1'b0,1'b1,8'h11,8'h22, 8'h00,1'b0,8'h3C,1'b1, 4'd9},
      '{1'b0,1'b0,1'b0,1'b1,8'h77,8'h88, 8'h88,1'b1,8'h00,1'b0, 4'd8},
      '{1'b0,1'b1,1'b1,1'b0,8'h77,8'h88, 8'h00,1'b0,8'h77,1'b1, 4'd9}
   };

   logic clk = 1'b0;
   logic rst_n, a_cap_clk, b_cap_clk, out_en_n, to_b, sel_a_stored, sel_b_stored;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic a_drv, b_drv;
   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bus_xcvr_reg #(.WIDTH(W)) uut (
      .rst_n(rst_n), .a_cap_clk(a_cap_clk), .b_cap_clk(b_cap_clk),
      .out_en_n(out_en_n), .to_b(to_b),
      .sel_a_stored(sel_a_stored), .sel_b_stored(sel_b_stored),
      .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
      .b_in(b_in), .b_out(b_out), .b_drv(b_drv));

   function automatic string tag_of(input logic [3:0] n);
      case (n)
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [2*W+1:0] act, input logic [2*W+1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic obs(input string req, input logic [W-1:0] ea, input logic ead,
                      input logic [W-1:0] eb, input logic ebd);
      #1;
      check(req, {ead ? a_out : a_out, a_drv, b_out, b_drv}, {ea, ead, eb, ebd});
   endtask

   task automatic set_ctl(input logic oen, input logic tob, input logic sa, input logic sb);
      out_en_n = oen; to_b = tob; sel_a_stored = sa; sel_b_stored = sb;
   endtask

   task automatic pulse_a();
      @(negedge clk) a_cap_clk = 1'b1;
      @(negedge clk) a_cap_clk = 1'b0;
   endtask

   task automatic pulse_b();
      @(negedge clk) b_cap_clk = 1'b1;
      @(negedge clk) b_cap_clk = 1'b0;
   endtask

   task automatic pulse_both();
      @(negedge clk) begin a_cap_clk = 1'b1; b_cap_clk = 1'b1; end
      @(negedge clk) begin a_cap_clk = 1'b0; b_cap_clk = 1'b0; end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      rst_n = 1'b0; a_cap_clk = 1'b0; b_cap_clk = 1'b0;
      a_in = '0; b_in = '0;
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: stored words are zero after reset
      @(negedge clk) begin a_in = 8'h5A; b_in = 8'h6B; set_ctl(1'b0, 1'b0, 1'b1, 1'b0); end
      obs("R1", 8'h00, 1'b1, 8'h00, 1'b0);
      @(negedge clk) set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
      obs("R1", 8'h00, 1'b0, 8'h00, 1'b1);

      // R4 / R2 / R3: capture both buses during isolation
      @(negedge clk) begin a_in = 8'h3C; b_in = 8'hA5; set_ctl(1'b1, 1'b0, 1'b0, 1'b0); end
      pulse_both();
      @(negedge clk) set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
      obs("R2", 8'h00, 1'b0, 8'h3C, 1'b1);
      @(negedge clk) set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
      obs("R3", 8'hA5, 1'b1, 8'h00, 1'b0);

      // vector table: routing, isolation, direction decode
      for (int i = 0; i < NV; i++) begin
         @(negedge clk) begin
            set_ctl(VECS[i].oen, VECS[i].tob, VECS[i].sa, VECS[i].sb);
            a_in = VECS[i].ain; b_in = VECS[i].bin;
         end
         obs(tag_of(VECS[i].req), VECS[i].ea, VECS[i].ead, VECS[i].eb, VECS[i].ebd);
      end

      // R11: bus changes without an edge leave the register untouched
      @(negedge clk) begin set_ctl(1'b0, 1'b1, 1'b0, 1'b1); a_in = 8'hF0; end
      obs("R11", 8'h00, 1'b0, 8'h3C, 1'b1);

      // R4: capture while B drives stored data
      @(negedge clk) a_in = 8'h5A;
      pulse_a();
      @(negedge clk) a_in = 8'hFF;
      obs("R4", 8'h00, 1'b0, 8'h5A, 1'b1);

      // R4: capture B while A drives stored data
      @(negedge clk) begin set_ctl(1'b0, 1'b0, 1'b1, 1'b0); b_in = 8'hC3; end
      pulse_b();
      @(negedge clk) b_in = 8'h00;
      obs("R4", 8'hC3, 1'b1, 8'h00, 1'b0);

      // R10: drive flags exclusive across every control combination
      for (int c = 0; c < 4; c++) begin
         @(negedge clk) set_ctl(c[1], c[0], 1'b0, 1'b0);
         #1;
         tests++;
         if (a_drv && b_drv) begin
            fails++;
            $display("FAIL R10: got a_drv=%b b_drv=%b expected not both", a_drv, b_drv);
         end
      end

      // R1: reset mid-run clears stored words
      do_reset();
      @(negedge clk) set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
      obs("R1", 8'h00, 1'b1, 8'h00, 1'b0);
      @(negedge clk) set_ctl(1'b0, 1'b1, 1'b0, 1'b1);
      obs("R1", 8'h00, 1'b0, 8'h00, 1'b1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule